// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps an asynchronous, strobe-driven DRAM refreshed on behalf of a memory controller. A free-running interval counter produces a refresh tick every `cfg_interval` clock cycles. Each tick adds one to a count of owed refreshes. A common choice of interval spreads a full row sweep evenly across the retention period: either 8192 rows in 128 ms or 4096 rows in 64 ms gives 15.625 µs between refreshes. Low-power parts that keep data for 256 ms can use a longer interval, so the interval is a run-time input and is not fixed at build time.

While refreshes are owed, the block raises a request toward the controller. The request turns urgent when the backlog grows past a programmable level; the controller should then close its open page and grant. After a grant, the block owns the RAS, CAS and WE strobes and the row address bus for one complete refresh cycle, and then returns them.

Two refresh styles are available. In CAS-first mode, CAS is driven low while RAS is still high, then RAS follows, and the device uses its own row counter. In row-address mode, the block drives its own row counter onto the address bus and pulses RAS with CAS held high. WE stays high at all times, so the CAS-first-with-WE-low combination, which enters the device's test mode, can never be produced. While the block owns the strobes, the controller must keep the data lines high-impedance.

Top module: `dram_refresh_sched`

## Requirements
- R1: A refresh tick occurs every `cfg_interval` cycles and adds one to the owed count. Writing 0 to `cfg_interval` disables ticking and clears the interval counter, so a new non-zero interval produces its first tick exactly `cfg_interval` cycles after it is applied.
- R2: `ref_req` is high exactly when the owed count is non-zero and the block does not own the strobes. `ref_urgent` is high exactly when the owed count is greater than `cfg_urgent_lvl`.
- R3: When `ref_req` and `ref_gnt` are both high at a clock edge, `ref_own` is high from that edge on. A grant while `ref_req` is low is ignored.
- R4: With `cfg_mode` = 0 (CAS-first), the sequence from takeover is as follows. For the first T_SU cycles, `cas_n`=0 and `ras_n`=1. For the next T_RAS cycles, both are 0. For the last T_RC−T_RAS cycles, both are 1. `we_n` is 1 in every cycle.
- R5: With `cfg_mode` = 1 (row address), `cas_n` stays 1 for the whole ownership. `ras_n` is 0 only during the T_RAS cycles that follow the first T_SU cycles. `ref_addr` carries the row counter throughout.
- R6: The row counter starts at 0 and advances by one at the end of each row-address refresh, wrapping from 2^ROW_W−1 to 0. A CAS-first refresh leaves it unchanged.
- R7: Ownership lasts exactly T_SU+T_RC cycles, which covers the full random cycle time. `ref_own` then drops, with both strobes high.
- R8: Finishing a refresh removes one from the owed count. When a tick and a finish fall on the same edge, the count is unchanged.
- R9: The refresh style is captured at takeover. A change of `cfg_mode` during ownership has no effect on the strobes of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_interval | input | IVL_W | Cycles between refresh ticks; 0 disables ticking |
| cfg_urgent_lvl | input | DEBT_W | Owed count above which the request becomes urgent |
| cfg_mode | input | 1 | 0 = CAS-first refresh, 1 = row-address refresh |
| ref_gnt | input | 1 | Controller grants the strobes |
| ref_req | output | 1 | Refresh owed and strobes not held |
| ref_urgent | output | 1 | Backlog exceeds the urgent level |
| ref_own | output | 1 | Block drives strobes and address; data lines must stay high-impedance |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| ref_addr | output | ROW_W | Row counter driven onto the address bus |

## Verification
The interval tick and the completion of a refresh both change the owed count, and they can land on the same clock edge. The bench provokes this by enabling a one-cycle interval for exactly the edge on which the last precharge cycle ends. With one refresh owed before the grant, a correct design still shows `ref_req` high after ownership is released, and a second refresh then clears it. A separate run, with no tick during the cycle, confirms that the request drops.

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int ROW_W  = 13,
  parameter int IVL_W  = 16,
  parameter int DEBT_W = 4,
  parameter int T_SU   = 1,
  parameter int T_RAS  = 8,
  parameter int T_RC   = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IVL_W-1:0]  cfg_interval,
  input  logic [DEBT_W-1:0] cfg_urgent_lvl,
  input  logic              cfg_mode,
  input  logic              ref_gnt,
  output logic              ref_req,
  output logic              ref_urgent,
  output logic              ref_own,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ROW_W-1:0]  ref_addr
);

  localparam int T_RP  = T_RC - T_RAS;
  localparam int TMR_W = $clog2(T_RC + T_SU + 1);
  localparam logic [TMR_W-1:0] SU_LAST  = TMR_W'(T_SU - 1);
  localparam logic [TMR_W-1:0] RAS_LAST = TMR_W'(T_RAS - 1);
  localparam logic [TMR_W-1:0] RP_LAST  = TMR_W'(T_RP - 1);
  localparam logic [DEBT_W-1:0] DEBT_MAX = '1;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_ACT, S_PRE} st_t;

  st_t               st_q;
  logic [TMR_W-1:0]  tmr_q;
  logic [IVL_W-1:0]  ivl_q;
  logic [DEBT_W-1:0] debt_q;
  logic [ROW_W-1:0]  row_q;
  logic              mode_q;
  logic              tick, done, ph_end;

  assign tick = (cfg_interval != '0) && (ivl_q >= cfg_interval - 1'b1);
  assign done = (st_q == S_PRE) && (tmr_q == RP_LAST);

  always_comb begin
    case (st_q)
      S_SETUP: ph_end = (tmr_q == SU_LAST);
      S_ACT:   ph_end = (tmr_q == RAS_LAST);
      S_PRE:   ph_end = (tmr_q == RP_LAST);
      default: ph_end = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ivl_q <= '0;
    else if (cfg_interval == '0 || tick) ivl_q <= '0;
    else ivl_q <= ivl_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      tmr_q  <= '0;
      mode_q <= 1'b0;
    end else if (st_q == S_IDLE) begin
      tmr_q <= '0;
      if (ref_req && ref_gnt) begin
        st_q   <= S_SETUP;
        mode_q <= cfg_mode;
      end
    end else if (ph_end) begin
      tmr_q <= '0;
      case (st_q)
        S_SETUP: st_q <= S_ACT;
        S_ACT:   st_q <= S_PRE;
        default: st_q <= S_IDLE;
      endcase
    end else begin
      tmr_q <= tmr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) debt_q <= '0;
    else case ({tick, done})
      2'b10:   if (debt_q != DEBT_MAX) debt_q <= debt_q + 1'b1;
      2'b01:   debt_q <= debt_q - 1'b1;
      default: debt_q <= debt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) row_q <= '0;
    else if (done && mode_q) row_q <= row_q + 1'b1;
  end

  assign ref_own    = (st_q != S_IDLE);
  assign ref_req    = (debt_q != '0) && !ref_own;
  assign ref_urgent = (debt_q > cfg_urgent_lvl);
  assign ras_n      = !(st_q == S_ACT);
  assign cas_n      = !(!mode_q && (st_q == S_SETUP || st_q == S_ACT));
  assign we_n       = 1'b1;
  assign ref_addr   = row_q;

  // R3
  own_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_own) |-> $past(ref_req && ref_gnt));

  // R4
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> $past(!cas_n));

  // R5
  ras_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> ref_own);

  // R6
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q) |=> (ref_addr == $past(ref_addr) + 1'b1));

  // R6
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && mode_q) |=> $stable(ref_addr));

  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ref_own) |-> ($past(done) && ras_n && cas_n));

  // R8
  debt_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && done) |=> $stable(debt_q));

  // R2
  urgent_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_urgent |-> (ref_req || ref_own || cfg_urgent_lvl != $past(cfg_urgent_lvl)
                    || debt_q != '0));

endmodule

// File: tb/tb_dram_refresh_sched.sv
`timescale 1ns/1ps
module tb_dram_refresh_sched;
  localparam int ROW_W = 3, IVL_W = 8, DEBT_W = 3;
  localparam int T_SU = 1, T_RAS = 3, T_RC = 5;
  localparam int TOTAL = T_SU + T_RC;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [IVL_W-1:0]  cfg_interval = '0;
  logic [DEBT_W-1:0] cfg_urgent_lvl = '1;
  logic cfg_mode = 1'b0, ref_gnt = 1'b0;
  logic ref_req, ref_urgent, ref_own, ras_n, cas_n, we_n;
  logic [ROW_W-1:0] ref_addr;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  dram_refresh_sched #(.ROW_W(ROW_W), .IVL_W(IVL_W), .DEBT_W(DEBT_W),
    .T_SU(T_SU), .T_RAS(T_RAS), .T_RC(T_RC)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_interval(cfg_interval),
    .cfg_urgent_lvl(cfg_urgent_lvl), .cfg_mode(cfg_mode), .ref_gnt(ref_gnt),
    .ref_req(ref_req), .ref_urgent(ref_urgent), .ref_own(ref_own),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ref_addr(ref_addr));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic add_debt(int k);
    cfg_interval = 8'd1;
    repeat (k) @(negedge clk);
    cfg_interval = '0;
  endtask

  task automatic run_ref(bit mode, int exp_row, bit flip, bit coin);
    chk("R3 req before grant", ref_req, 1);
    cfg_mode = mode;
    ref_gnt  = 1'b1;
    @(negedge clk);
    chk("R3 own after grant", ref_own, 1);
    ref_gnt = 1'b0;
    for (int i = 0; i < TOTAL; i++) begin
      bit act = (i >= T_SU) && (i < T_SU + T_RAS);
      chk("R7 own held", ref_own, 1);
      chk("R2 req low while owned", ref_req, 0);
      chk("R4 we_n high", we_n, 1);
      chk(mode ? "R5 ras_n phase" : "R4 ras_n phase", ras_n, act ? 0 : 1);
      if (mode) begin
        chk("R5 cas_n high", cas_n, 1);
        chk("R5 row address", ref_addr, exp_row);
      end else begin
        chk("R4 cas_n phase", cas_n, (i < T_SU + T_RAS) ? 0 : 1);
      end
      if (flip && i == 1) cfg_mode = !mode;
      if (coin && i == TOTAL - 1) cfg_interval = 8'd1;
      @(negedge clk);
    end
    cfg_interval = '0;
    cfg_mode = mode;
    chk("R7 released", ref_own, 0);
    chk("R7 strobes idle", ras_n & cas_n, 1);
  endtask

  task automatic t_reset;
    chk("R2 req reset", ref_req, 0);
    chk("R2 urgent reset", ref_urgent, 0);
    chk("R7 own reset", ref_own, 0);
    chk("R4 strobes reset", {ras_n, cas_n, we_n}, 7);
    chk("R6 row reset", ref_addr, 0);
  endtask

  task automatic t_grant_ignored;
    ref_gnt = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3 grant without req", ref_own, 0);
    ref_gnt = 1'b0;
  endtask

  task automatic t_interval;
    cfg_interval = 8'd10;
    repeat (9) @(negedge clk);
    chk("R1 no tick before interval", ref_req, 0);
    @(negedge clk);
    chk("R1 tick at interval", ref_req, 1);
    cfg_interval = '0;
    repeat (12) @(negedge clk);
    chk("R1 disabled stays single", ref_req, 1);
  endtask

  task automatic t_cbr;
    run_ref(1'b0, 0, 1'b0, 1'b0);
    chk("R8 debt cleared", ref_req, 0);
  endtask

  task automatic t_ror_wrap;
    for (int r = 0; r < 9; r++) begin
      add_debt(1);
      run_ref(1'b1, r % 8, 1'b0, 1'b0);
    end
    chk("R6 row after wrap", ref_addr, 1);
  endtask

  task automatic t_urgent;
    cfg_urgent_lvl = 3'd2;
    add_debt(2);
    chk("R2 not urgent at level", ref_urgent, 0);
    add_debt(1);
    chk("R2 urgent above level", ref_urgent, 1);
    run_ref(1'b0, 0, 1'b0, 1'b0);
    chk("R2 urgent cleared", ref_urgent, 0);
    chk("R2 req still owed", ref_req, 1);
    run_ref(1'b0, 0, 1'b0, 1'b0);
    run_ref(1'b0, 0, 1'b0, 1'b0);
    chk("R8 backlog drained", ref_req, 0);
    cfg_urgent_lvl = '1;
  endtask

  task automatic t_mode_flip;
    add_debt(1);
    run_ref(1'b0, 0, 1'b1, 1'b0);
    chk("R9 row unchanged after flip", ref_addr, 1);
    add_debt(1);
    run_ref(1'b1, 1, 1'b1, 1'b0);
    chk("R9 row advanced after flip", ref_addr, 2);
  endtask

  task automatic t_coincide;
    add_debt(1);
    run_ref(1'b0, 0, 1'b0, 1'b1);
    chk("R8 tick with finish keeps debt", ref_req, 1);
    run_ref(1'b0, 0, 1'b0, 1'b0);
    chk("R8 debt cleared after second", ref_req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_grant_ignored;
    t_interval;
    t_cbr;
    t_ror_wrap;
    t_urgent;
    t_mode_flip;
    t_coincide;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    fails++;
    $display("FAIL R7 watchdog act=running exp=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule